// File: doc/BRIEF.md
# Legacy INTx message generator

This block turns a level-style interrupt request wire into a stream of PCI Express legacy interrupt message requests. Each time the request level goes from low to high, an Assert_INTA request is queued. Each time it goes from high to low, a Deassert_INTA request is queued. Requests are offered one at a time on a valid/ready interface to a downstream packet builder, which turns them into transaction-layer packets.

The request wire has two possible meanings. It counts as a legacy interrupt only when three things hold: the block is built as an endpoint, the interrupt-pin setting selects INTA, and the MSI enable input is low. If MSI is switched on while the virtual INTA wire is asserted, the block first sends a Deassert_INTA and then stays quiet.

If the input toggles while the consumer stalls, the toggles are kept as a pending count. The message kind always alternates, so order is kept. A small counter is enough for this because the message kind follows from the current state of the virtual wire.

Top module: `intx_msg_gen`

## Requirements
- R1: A low-to-high change on `irq_level_i` yields exactly one request with `msg_kind_o` = 0 (assert). With the default two synchroniser stages, `msg_valid_o` rises after the third rising clock edge that samples the new level.
- R2: A high-to-low change on `irq_level_i` yields exactly one request with `msg_kind_o` = 1 (deassert), with the same latency as R1.
- R3: While `msi_en_i` is 1, changes on `irq_level_i` produce no request. When `msi_en_i` returns to 0 while the input is high, one assert request follows one cycle later.
- R4: Raising `msi_en_i` while the virtual wire is asserted queues one deassert request, visible after the next rising edge.
- R5: With `IS_ROOT_PORT` = 1, `msg_valid_o` never rises, whatever the input does.
- R6: `INT_PIN` = 1 enables INTA generation. `INT_PIN` = 0 disables legacy interrupts, and `msg_valid_o` stays 0.
- R7: While `msg_valid_o` is 1 and `msg_ready_i` is 0, `msg_valid_o` and `msg_kind_o` stay unchanged on the next cycle.
- R8: Accepted requests alternate in kind. No edge is lost while fewer than 2^`PEND_W` toggles are pending. Once drained, the level implied by the accepted messages equals the current gated input level.
- R9: When the pending count is at its maximum (2^`PEND_W`-1) and another edge arrives with no handshake, the count drops by one. The newest pending toggle pair cancels, so the level after draining is still correct.
- R10: Synchronous active-high `rst` clears the synchroniser, the edge history and the pending count, and marks the virtual wire deasserted. The first request after reset is an assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | 1 | Interrupt request level (asynchronous) |
| msi_en_i | input | 1 | MSI enable state; 1 disables legacy generation |
| msg_valid_o | output | 1 | A message request is offered |
| msg_kind_o | output | 1 | 0 = Assert_INTA, 1 = Deassert_INTA |
| msg_ready_i | input | 1 | Consumer accepts the offered request this cycle |

## Verification
An input-level change reaches `msg_valid_o` three rising edges later: two synchroniser flops, then the pending counter. A change on `msi_en_i` bypasses the synchroniser and shows after one edge. A handshake clears `msg_valid_o` on the very next edge when nothing else is pending. The bench drives inputs on falling edges and samples at the falling edge that follows the edge where each result is due. It also checks one sample earlier to confirm nothing appears early. For the stall sweeps, it waits a settle time longer than the input latency before draining.

// File: rtl/intx_pkg.sv
package intx_pkg;

    typedef enum logic {
        MSG_ASSERT   = 1'b0,
        MSG_DEASSERT = 1'b1
    } intx_msg_e;

    typedef struct packed {
        logic level;   // gated, synchronised request level
        logic toggled; // level differs from the previous cycle
    } lvl_evt_t;

    // The next message kind follows from the current virtual wire state.
    function automatic intx_msg_e kind_for(input logic wire_hi);
        return wire_hi ? MSG_DEASSERT : MSG_ASSERT;
    endfunction

    function automatic logic legacy_allowed(input bit root_port, input int unsigned pin_sel);
        return (!root_port) && (pin_sel == 1);
    endfunction

endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/intx_edge_gate.sv
module intx_edge_gate
    import intx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_lvl,
    input  logic     enable,
    output lvl_evt_t evt,
    output logic     prev_q
);
    logic gated;

    always_comb begin
        gated       = sync_lvl & enable;
        evt.level   = gated;
        evt.toggled = gated ^ prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= gated;
    end
endmodule

// File: rtl/intx_msg_queue.sv
module intx_msg_queue
    import intx_pkg::*;
#(
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_in,
    input  logic              msg_ready_i,
    output logic              msg_valid_o,
    output intx_msg_e         msg_kind_o,
    output logic              wire_q,
    output logic [PEND_W-1:0] pend_q
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] ONE      = PEND_W'(1);

    logic              take;
    logic [PEND_W-1:0] pend_nxt;

    always_comb begin
        msg_valid_o = (pend_q != '0);
        msg_kind_o  = kind_for(wire_q);
        take        = msg_valid_o && msg_ready_i;
        unique case ({edge_in, take})
            2'b10:   pend_nxt = (pend_q == PEND_MAX) ? (PEND_MAX - ONE) : (pend_q + ONE);
            2'b01:   pend_nxt = pend_q - ONE;
            default: pend_nxt = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            wire_q <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            if (take) wire_q <= ~wire_q;
        end
    end
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen
    import intx_pkg::*;
#(
    parameter bit IS_ROOT_PORT = 1'b0,
    parameter int INT_PIN      = 1,
    parameter int SYNC_STAGES  = 2,
    parameter int PEND_W       = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_level_i,
    input  logic msi_en_i,
    output logic msg_valid_o,
    output logic msg_kind_o,
    input  logic msg_ready_i
);
    localparam bit LEGACY_OK = legacy_allowed(IS_ROOT_PORT, INT_PIN);

    logic              wire_q;
    logic [PEND_W-1:0] pend_q;
    logic              lvl_prev_q;

    if (LEGACY_OK) begin : g_legacy
        logic      sync_lvl;
        lvl_evt_t  evt;
        intx_msg_e kind;

        intx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (irq_level_i),
            .q   (sync_lvl)
        );

        intx_edge_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .sync_lvl (sync_lvl),
            .enable   (~msi_en_i),
            .evt      (evt),
            .prev_q   (lvl_prev_q)
        );

        intx_msg_queue #(.PEND_W(PEND_W)) u_queue (
            .clk         (clk),
            .rst         (rst),
            .edge_in     (evt.toggled),
            .msg_ready_i (msg_ready_i),
            .msg_valid_o (msg_valid_o),
            .msg_kind_o  (kind),
            .wire_q      (wire_q),
            .pend_q      (pend_q)
        );

        assign msg_kind_o = kind;
    end else begin : g_off
        assign msg_valid_o = 1'b0;
        assign msg_kind_o  = 1'b0;
        assign wire_q      = 1'b0;
        assign pend_q      = '0;
        assign lvl_prev_q  = 1'b0;
    end
endmodule

// File: rtl/intx_msg_gen_chk.sv
module intx_msg_gen_chk #(
    parameter bit LEGACY_OK = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic msi_en_i,
    input logic msg_valid_o,
    input logic msg_kind_o,
    input logic msg_ready_i,
    input logic wire_q,
    input logic pend_lsb,
    input logic lvl_prev_q
);
    logic seen;
    logic last_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= 1'b0;
            last_kind <= 1'b0;
        end else if (msg_valid_o && msg_ready_i) begin
            seen      <= 1'b1;
            last_kind <= msg_kind_o;
        end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && (msg_kind_o == $past(msg_kind_o))));

    a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && msg_ready_i && seen) |-> (msg_kind_o != last_kind));

    a_r10_first_assert: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && msg_ready_i && !seen) |-> (msg_kind_o == 1'b0));

    a_r8_level_track: assert property (@(posedge clk) disable iff (rst)
        ((wire_q ^ pend_lsb) == lvl_prev_q));

    a_r3_msi_quiet: assert property (@(posedge clk) disable iff (rst)
        (msi_en_i && $past(msi_en_i) && !msg_valid_o) |=> !msg_valid_o);

    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !LEGACY_OK |-> !msg_valid_o);

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!msg_valid_o && !wire_q));
endmodule

bind intx_msg_gen intx_msg_gen_chk #(.LEGACY_OK(LEGACY_OK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msi_en_i    (msi_en_i),
    .msg_valid_o (msg_valid_o),
    .msg_kind_o  (msg_kind_o),
    .msg_ready_i (msg_ready_i),
    .wire_q      (wire_q),
    .pend_lsb    (pend_q[0]),
    .lvl_prev_q  (lvl_prev_q)
);

// File: tb/sim_intx_msg_gen.sv
`timescale 1ns/1ps
module sim_intx_msg_gen;
    localparam int PEND_W = 2;
    localparam int CAP    = (1 << PEND_W) - 1;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    logic msi = 1'b0;
    logic rdy = 1'b0;
    logic v0, k0, v1, k1, v2, k2;

    int checks = 0;
    int errors = 0;
    int quiet_bad = 0;
    logic mwire = 1'b0; // level implied by accepted messages

    always #4 clk = ~clk;

    intx_msg_gen #(.PEND_W(PEND_W)) u0 (
        .clk(clk), .rst(rst), .irq_level_i(irq), .msi_en_i(msi),
        .msg_valid_o(v0), .msg_kind_o(k0), .msg_ready_i(rdy));
    intx_msg_gen #(.IS_ROOT_PORT(1'b1), .PEND_W(PEND_W)) u1 (
        .clk(clk), .rst(rst), .irq_level_i(irq), .msi_en_i(msi),
        .msg_valid_o(v1), .msg_kind_o(k1), .msg_ready_i(rdy));
    intx_msg_gen #(.INT_PIN(0), .PEND_W(PEND_W)) u2 (
        .clk(clk), .rst(rst), .irq_level_i(irq), .msi_en_i(msi),
        .msg_valid_o(v2), .msg_kind_o(k2), .msg_ready_i(rdy));

    always @(negedge clk) if (!rst && (v1 || v2 || k1 || k2)) quiet_bad++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drain with ready high; returns message count and checks alternation.
    task automatic drain(input string req, output int got);
        got = 0;
        rdy = 1'b1;
        for (int i = 0; i < 20 && v0; i++) begin
            chk(k0 == mwire, req, k0, mwire);
            mwire = ~mwire;
            got++;
            step(1);
        end
        rdy = 1'b0;
    endtask

    initial begin
        int got;
        int exp_cnt;
        int seen_v;
        logic k_hold;

        step(3);
        chk(v0 == 1'b0, "R10", v0, 0);
        rst = 1'b0;
        step(2);
        chk(v0 == 1'b0, "R10", v0, 0);

        // R1: rising edge, latency
        irq = 1'b1;
        step(LAT - 1);
        chk(v0 == 1'b0, "R1", v0, 0);
        step(1);
        chk(v0 == 1'b1 && k0 == 1'b0, "R1", {v0, k0}, 2);
        // R7: stall holds
        k_hold = k0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk(v0 == 1'b1 && k0 == k_hold, "R7", {v0, k0}, {1'b1, k_hold});
        end
        drain("R1", got);
        chk(got == 1, "R1", got, 1);
        step(1);
        chk(v0 == 1'b0, "R1", v0, 0);

        // R2: falling edge
        irq = 1'b0;
        step(LAT - 1);
        chk(v0 == 1'b0, "R2", v0, 0);
        step(1);
        chk(v0 == 1'b1 && k0 == 1'b1, "R2", {v0, k0}, 3);
        drain("R2", got);
        chk(got == 1, "R2", got, 1);

        // R8 / R9: sweep toggle counts under stall
        for (int n = 1; n <= 7; n++) begin
            exp_cnt = 0;
            for (int t = 0; t < n; t++) begin
                irq = ~irq;
                exp_cnt = (exp_cnt == CAP) ? CAP - 1 : exp_cnt + 1;
                step(2);
            end
            step(LAT + 2);
            drain((n > CAP) ? "R9" : "R8", got);
            chk(got == exp_cnt, (n > CAP) ? "R9" : "R8", got, exp_cnt);
            chk(mwire == irq, "R8", mwire, irq);
        end

        // R8: toggles with ready held high
        rdy = 1'b1;
        got = 0;
        for (int i = 0; i < 24; i++) begin
            if (i < 8 && i % 2 == 0) irq = ~irq;
            if (v0) begin
                chk(k0 == mwire, "R8", k0, mwire);
                mwire = ~mwire;
                got++;
            end
            step(1);
        end
        rdy = 1'b0;
        chk(got == 4, "R8", got, 4);
        chk(mwire == irq, "R8", mwire, irq);

        // R4: MSI enabled while wire asserted
        irq = 1'b1;
        step(LAT + 2);
        drain("R4", got);
        chk(mwire == 1'b1, "R4", mwire, 1);
        msi = 1'b1;
        step(1);
        chk(v0 == 1'b1 && k0 == 1'b1, "R4", {v0, k0}, 3);
        drain("R4", got);
        chk(got == 1, "R4", got, 1);

        // R3: ignored while MSI enabled
        seen_v = 0;
        irq = 1'b0;
        for (int i = 0; i < 6; i++) begin step(1); if (v0) seen_v++; end
        irq = 1'b1;
        for (int i = 0; i < 6; i++) begin step(1); if (v0) seen_v++; end
        chk(seen_v == 0, "R3", seen_v, 0);
        msi = 1'b0;
        step(1);
        chk(v0 == 1'b1 && k0 == 1'b0, "R3", {v0, k0}, 2);
        drain("R3", got);
        chk(got == 1, "R3", got, 1);

        // R10: reset mid-traffic clears history
        irq = 1'b0;
        step(LAT + 1);
        chk(v0 == 1'b1, "R10", v0, 1);
        irq = 1'b1;
        rst = 1'b1;
        step(1);
        chk(v0 == 1'b0, "R10", v0, 0);
        rst = 1'b0;
        mwire = 1'b0;
        step(LAT - 1);
        chk(v0 == 1'b0, "R10", v0, 0);
        step(1);
        chk(v0 == 1'b1 && k0 == 1'b0, "R10", {v0, k0}, 2);
        drain("R10", got);
        chk(got == 1, "R10", got, 1);

        // R5 / R6: disabled variants stayed silent throughout
        chk(quiet_bad == 0, "R5", quiet_bad, 0);
        chk(quiet_bad == 0, "R6", quiet_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule